// File: doc/BRIEF.md
# Kernel Launch Control Register Slave

This block is the register front end of a compute kernel. A host-side master reaches it through a memory-mapped slave port with 64-bit data, byte enables and a byte address. Each 64-bit register holds two 32-bit launch parameters, one in the upper half and one in the lower half. The parameters are the workgroup size and dimension count, three global sizes, three workgroup counts, three local sizes and the first global offset. They drive a parameter bus into the kernel core all the time.

The control word sits at offset 0x0. Writing a 1 to its bit 0 while the kernel is idle sends the core a one-cycle start pulse and marks the kernel busy. When the core raises its done input, the busy state ends and a level interrupt rises. The interrupt stays high until the host writes the control word again. Reads return data one cycle after the request, flagged by a valid strobe.

Top module: `launch_csr`

## Requirements
- R1: After reset (active low) every parameter register and parameter output is zero, and start_o, irq_o and rvalid_o are low.
- R2: A write to offset 0x0 with byte lane 0 enabled and wdata bit 0 set, while the kernel is idle, raises start_o for exactly the next cycle and makes the kernel busy. The same write with byte lane 0 disabled starts nothing.
- R3: A start write that arrives while the kernel is busy is ignored: no start pulse, and the kernel stays busy.
- R4: When done_i is high while busy, the kernel becomes idle and irq_o rises. irq_o stays high until a write to offset 0x0 with lane 0 enabled, or a new start, clears it. done_i while idle has no effect.
- R5: A read of offset 0x0 returns the busy flag in bit 1 and the interrupt (done) flag in bit 2. All other bits read zero.
- R6: The parameter map is {upper, lower}: 0x28 {workgroup size, workgroup dimensions}, 0x30 {global size 1, global size 0}, 0x38 {workgroup count 0, global size 2}, 0x40 {workgroup count 2, workgroup count 1}, 0x48 {local size 1, local size 0}, 0x50 {global offset 0, local size 2}. Each field appears on its own output port.
- R7: Byte enable bit n updates only wdata bits [8n+7:8n] of the addressed register. Lanes whose enable is clear keep their old value.
- R8: rvalid_o is high exactly one cycle after each cycle with rd_en high, and rdata_o carries the value of the register addressed in that request.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.
- R10: A full 64-bit register can be written on every clock cycle, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address; bits [2:0] ignored |
| wdata | input | 64 | Write data |
| be | input | 8 | Byte enables, one per lane |
| rdata_o | output | 64 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en |
| done_i | input | 1 | Completion from the kernel core |
| start_o | output | 1 | One-cycle start pulse to the core |
| irq_o | output | 1 | Level completion interrupt |
| wg_dims_o | output | 32 | Workgroup dimensions |
| wg_size_o | output | 32 | Workgroup size |
| gsize0_o | output | 32 | Global size 0 |
| gsize1_o | output | 32 | Global size 1 |
| gsize2_o | output | 32 | Global size 2 |
| ngrp0_o | output | 32 | Workgroup count 0 |
| ngrp1_o | output | 32 | Workgroup count 1 |
| ngrp2_o | output | 32 | Workgroup count 2 |
| lsize0_o | output | 32 | Local size 0 |
| lsize1_o | output | 32 | Local size 1 |
| lsize2_o | output | 32 | Local size 2 |
| goff0_o | output | 32 | Global offset 0 |

## Verification
The assertions check on every cycle that the start pulse lasts one cycle and only leaves the idle state, that done while busy always ends in a raised interrupt, that a new start drops the interrupt, and that read data comes back after exactly one cycle, as zero for unmapped offsets. The bench scenarios cover the rest. They show where each field lands in the address map, how partial byte enables merge into a register, that back-to-back writes are all kept, and that a start written while busy or with lane 0 disabled does nothing. They also show that the interrupt holds over idle cycles until the host clears it.

// File: rtl/launch_csr.sv
module launch_csr #(
  parameter int ADDR_W   = 8,
  parameter int PRM_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  input  logic [7:0]        be,
  output logic [63:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              done_i,
  output logic              start_o,
  output logic              irq_o,
  output logic [31:0]       wg_dims_o,
  output logic [31:0]       wg_size_o,
  output logic [31:0]       gsize0_o,
  output logic [31:0]       gsize1_o,
  output logic [31:0]       gsize2_o,
  output logic [31:0]       ngrp0_o,
  output logic [31:0]       ngrp1_o,
  output logic [31:0]       ngrp2_o,
  output logic [31:0]       lsize0_o,
  output logic [31:0]       lsize1_o,
  output logic [31:0]       lsize2_o,
  output logic [31:0]       goff0_o
);
  localparam int NREG  = 6;
  localparam int LANES = 8;
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] widx;
  logic [63:0]      prm_q [NREG];
  logic             busy_q;
  logic             ctl_wr;
  logic             go;
  logic [63:0]      rd_mux;

  assign widx   = addr[ADDR_W-1:3];
  assign ctl_wr = wr_en && (widx == '0) && be[0];
  assign go     = ctl_wr && wdata[0] && !busy_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prm_q[r] <= '0;
      end else if (wr_en && widx == IDX_W'(PRM_BASE + r)) begin
        for (int b = 0; b < LANES; b++)
          if (be[b]) prm_q[r][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      busy_q  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      start_o <= go;
      if (go)
        busy_q <= 1'b1;
      else if (busy_q && done_i)
        busy_q <= 1'b0;
      if (busy_q && done_i)
        irq_o <= 1'b1;
      else if (ctl_wr)
        irq_o <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (widx == '0)
      rd_mux = {61'd0, irq_o, busy_q, 1'b0};
    for (int r = 0; r < NREG; r++)
      if (widx == IDX_W'(PRM_BASE + r)) rd_mux = prm_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= rd_mux;
    end
  end

  assign wg_dims_o = prm_q[0][31:0];
  assign wg_size_o = prm_q[0][63:32];
  assign gsize0_o  = prm_q[1][31:0];
  assign gsize1_o  = prm_q[1][63:32];
  assign gsize2_o  = prm_q[2][31:0];
  assign ngrp0_o   = prm_q[2][63:32];
  assign ngrp1_o   = prm_q[3][31:0];
  assign ngrp2_o   = prm_q[3][63:32];
  assign lsize0_o  = prm_q[4][31:0];
  assign lsize1_o  = prm_q[4][63:32];
  assign lsize2_o  = prm_q[5][31:0];
  assign goff0_o   = prm_q[5][63:32];
endmodule

module launch_csr_chk #(
  parameter int ADDR_W   = 8,
  parameter int PRM_BASE = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [63:0]       rdata_o,
  input logic              rvalid_o,
  input logic              done_i,
  input logic              start_o,
  input logic              irq_o,
  input logic              busy_q
);
  localparam int IDX_W = ADDR_W - 3;
  logic [IDX_W-1:0] idx;
  logic             unmapped;
  assign idx      = addr[ADDR_W-1:3];
  assign unmapped = (idx != '0) && ((idx < IDX_W'(PRM_BASE)) || (idx > IDX_W'(PRM_BASE + 5)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  a_r2_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_q);
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_q));
  a_r4_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> (irq_o && !busy_q));
  a_r4_start_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !irq_o);
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid_o);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata_o == 64'd0));
endmodule

bind launch_csr launch_csr_chk #(.ADDR_W(ADDR_W), .PRM_BASE(PRM_BASE)) u_chk (.*);

// File: tb/sim_launch_csr.sv
module sim_launch_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, done_i = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  be = '0;
  logic [63:0] rdata_o;
  logic        rvalid_o, start_o, irq_o;
  logic [31:0] wg_dims_o, wg_size_o, gsize0_o, gsize1_o, gsize2_o;
  logic [31:0] ngrp0_o, ngrp1_o, ngrp2_o, lsize0_o, lsize1_o, lsize2_o, goff0_o;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  launch_csr u0 (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] b);
    wr_en = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "R8 unexpected rvalid");
      end else begin
        automatic logic [63:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata_o, e, t);
      end
    end
  end

  function automatic logic [63:0] pval(int r);
    return {32'h1000 * 32'(r + 1) + 32'hA, 32'h0100 * 32'(r + 1) + 32'h5};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] mask, merged;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_o, 0, "R1 start_o after reset");
    chk(irq_o, 0, "R1 irq_o after reset");
    chk(rvalid_o, 0, "R1 rvalid_o after reset");
    chk(goff0_o, 0, "R1 goff0_o after reset");
    rd(8'h28, 64'd0, "R1 reg 0x28 after reset");
    rd(8'h00, 64'd0, "R5 status idle");

    for (int r = 0; r < 6; r++) wr(8'(8'h28 + 8 * r), pval(r), 8'hFF);
    for (int r = 0; r < 6; r++) rd(8'(8'h28 + 8 * r), pval(r), "R10 back-to-back write readback");
    chk(wg_dims_o, pval(0)[31:0], "R6 wg_dims_o");
    chk(wg_size_o, pval(0)[63:32], "R6 wg_size_o");
    chk(gsize0_o, pval(1)[31:0], "R6 gsize0_o");
    chk(gsize1_o, pval(1)[63:32], "R6 gsize1_o");
    chk(gsize2_o, pval(2)[31:0], "R6 gsize2_o");
    chk(ngrp0_o, pval(2)[63:32], "R6 ngrp0_o");
    chk(ngrp1_o, pval(3)[31:0], "R6 ngrp1_o");
    chk(ngrp2_o, pval(3)[63:32], "R6 ngrp2_o");
    chk(lsize0_o, pval(4)[31:0], "R6 lsize0_o");
    chk(lsize1_o, pval(4)[63:32], "R6 lsize1_o");
    chk(lsize2_o, pval(5)[31:0], "R6 lsize2_o");
    chk(goff0_o, pval(5)[63:32], "R6 goff0_o");

    mask = 64'h0000_0000_00FF_FF00;
    merged = (pval(1) & ~mask) | mask;
    wr(8'h30, {64{1'b1}}, 8'b0000_0110);
    rd(8'h30, merged, "R7 partial byte enables");
    mask = 64'hFF00_0000_0000_0000;
    merged = (pval(5) & ~mask) | (64'h5A5A_5A5A_5A5A_5A5A & mask);
    wr(8'h50, 64'h5A5A_5A5A_5A5A_5A5A, 8'b1000_0000);
    rd(8'h50, merged, "R7 top lane only");

    wr(8'h58, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF);
    wr(8'h08, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF);
    rd(8'h58, 64'd0, "R9 unmapped 0x58 reads zero");
    rd(8'h08, 64'd0, "R9 unmapped 0x08 reads zero");
    rd(8'hF8, 64'd0, "R9 unmapped 0xF8 reads zero");
    rd(8'h28, pval(0), "R9 unmapped write left 0x28 intact");

    wr(8'h00, 64'd1, 8'hFE);
    chk(start_o, 0, "R2 lane 0 disabled gives no start");
    rd(8'h00, 64'd0, "R2 still idle after masked start");

    wr(8'h00, 64'd1, 8'h01);
    chk(start_o, 1, "R2 start pulse");
    @(negedge clk);
    chk(start_o, 0, "R2 start pulse one cycle");
    rd(8'h00, 64'd2, "R5 status busy");

    wr(8'h00, 64'd1, 8'h01);
    chk(start_o, 0, "R3 start while busy ignored");
    rd(8'h00, 64'd2, "R3 still busy");

    done_i = 1'b1; @(negedge clk); done_i = 1'b0;
    chk(irq_o, 1, "R4 irq on done");
    repeat (4) @(negedge clk);
    chk(irq_o, 1, "R4 irq held");
    rd(8'h00, 64'd4, "R5 status done");
    wr(8'h00, 64'd0, 8'h01);
    chk(irq_o, 0, "R4 irq cleared by control write");
    rd(8'h00, 64'd0, "R5 status cleared");

    done_i = 1'b1; @(negedge clk); done_i = 1'b0;
    chk(irq_o, 0, "R4 done while idle ignored");

    wr(8'h00, 64'd1, 8'h01);
    done_i = 1'b1; @(negedge clk); done_i = 1'b0;
    chk(irq_o, 1, "R4 irq second run");
    wr(8'h00, 64'd1, 8'h01);
    chk(start_o, 1, "R4 restart pulse");
    chk(irq_o, 0, "R4 restart clears irq");
    done_i = 1'b1; @(negedge clk); done_i = 1'b0;

    @(negedge clk);
    chk(rvalid_o, 0, "R8 rvalid low when idle");
    repeat (2) @(negedge clk);
    chk(64'(exp_q.size()), 0, "R8 all reads answered");
    summary();
  end
endmodule